// File: doc/BRIEF.md
# Banked Memory Subsystem with Address Decode

The block is a byte-wide memory that sits behind one address bus and is split into four equal banks. The two most significant address bits pick a bank through a 2-to-4 decode, and that decode is gated by a memory-enable input. The remaining low address bits go to every bank in parallel. Bank 0 is a read-only table whose contents are fixed when the block is built. Banks 1 to 3 are writable static RAM. A parameter selects a sparse map. In that map only banks 0 and 2 are present, and the regions that would hold banks 1 and 3 answer nothing.

The address width is a parameter. With `ADDR_W = 16` the block covers the full 64K space, with banks of 16K x 8. The default of 12 gives a 4K space with 1K banks, which keeps the default storage small. The decode does not change with the width: bank b covers the addresses b·S to b·S+S−1, where S = 2^(ADDR_W−2). Reads are registered, so a byte arrives one clock after its request. The read-data output always has exactly one source, and it is zero whenever no bank answered.

Top module: `mem_subsys`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `rvalid` is 0 and `rdata` is 00H.
- R2: With `mem_en` high in the dense map, `bank_cs` is one-hot and bit `addr[ADDR_W-1:ADDR_W-2]` is set. This holds at the first and the last address of every bank. The last address of a bank is its start plus the bank size minus one.
- R3: With `mem_en` low, `bank_cs` is 0000b. No read completes and no byte is stored, whatever `wr_en` and `rd_en` are.
- R4: A read is a cycle with `mem_en=1`, `rd_en=1` and `wr_en=0`. A read of bank 0 at offset o gives `rvalid=1` one clock later, with `rdata = o[7:0] ^ {o[11:8],o[11:8]} ^ 8'h5A`, where o is the low address bits zero-extended.
- R5: A write is a cycle with `mem_en=1`, `wr_en=1` and a RAM bank selected. It stores `wdata` on that clock edge, and a later read of the same address returns it.
- R6: A write to the bank 0 region is ignored. The bank 0 contents keep the R4 pattern, and the same offset in every other bank is left unchanged.
- R7: When `wr_en` and `rd_en` are both high, the write is performed and no read happens: `rvalid` is 0 on the next cycle.
- R8: In the cycle after a request that is not a read, `rvalid` is 0 and `rdata` is 00H. This covers `rd_en` low, `mem_en` low and a request to an unmapped region.
- R9: With `SPARSE_MAP=1`, top-bit patterns 01b and 11b set no chip select. Reads there give `rvalid=0`, and writes there leave bank 2 and bank 0 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_en | input | 1 | Global memory enable, qualifies all decode |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Output (read) enable |
| addr | input | ADDR_W | Byte address; top two bits select the bank |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data, 00H when nothing was read |
| rvalid | output | 1 | High one clock after a completed read |
| bank_cs | output | 4 | Per-bank chip selects, combinational from `mem_en` and `addr` |

## Verification
The chip selects are combinational, so the bench checks them 1 ns after it drives each input vector, inside the same cycle. The bench also predicts what `rvalid` and `rdata` will show one clock later and queues that prediction. A monitor pops the queue 2 ns after the following rising edge, which lines every prediction up with the single register stage on the read path. A dense instance and a sparse instance receive the same stimulus, and each is compared against its own reference memory. This lets ignored writes show up as unchanged bytes on later reads.

// File: rtl/mem_sys_pkg.sv
package mem_sys_pkg;
    localparam int DATA_W    = 8;
    localparam int NUM_BANKS = 4;
    localparam int SEL_W     = 2;

    typedef logic [DATA_W-1:0]    byte_t;
    typedef logic [NUM_BANKS-1:0] bank_vec_t;

    typedef struct packed {
        logic wr;
        logic rd;
    } req_t;

    // Fixed content of the read-only bank as a function of its offset.
    function automatic byte_t rom_byte(input logic [31:0] off);
        return off[7:0] ^ {off[11:8], off[11:8]} ^ 8'h5A;
    endfunction

    // Whether bank b exists in the chosen map.
    function automatic bit bank_present(input int b, input bit sparse);
        return !sparse || ((b % 2) == 0);
    endfunction
endpackage

// File: rtl/bank_decode.sv
module bank_decode
    import mem_sys_pkg::*;
#(
    parameter bit SPARSE_MAP = 1'b0
) (
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output bank_vec_t        cs
);
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cs
        if (bank_present(b, SPARSE_MAP)) begin : g_pop
            assign cs[b] = en && (sel == SEL_W'(b));
        end else begin : g_hole
            assign cs[b] = 1'b0;
        end
    end
endmodule

// File: rtl/rom_bank.sv
module rom_bank
    import mem_sys_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd,
    input  logic [AW-1:0] off,
    output byte_t         q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (rd)
            q <= rom_byte(32'(off));
    end
endmodule

// File: rtl/ram_bank.sv
module ram_bank
    import mem_sys_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          wr,
    input  logic          rd,
    input  logic [AW-1:0] off,
    input  byte_t         d,
    output byte_t         q
);
    localparam int DEPTH = 1 << AW;

    byte_t store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr)
            store[off] <= d;
        if (rd)
            q <= store[off];
    end
endmodule

// File: rtl/mem_subsys.sv
module mem_subsys
    import mem_sys_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter bit SPARSE_MAP = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mem_en,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              rvalid,
    output logic [3:0]        bank_cs
);
    localparam int BANK_AW = ADDR_W - SEL_W;

    bank_vec_t          cs;
    bank_vec_t          rd_vec;
    bank_vec_t          wr_vec;
    bank_vec_t          src_q;
    byte_t              bank_q [NUM_BANKS];
    logic [BANK_AW-1:0] off;
    req_t               req;

    assign off    = addr[BANK_AW-1:0];
    assign req.wr = wr_en;
    assign req.rd = rd_en && !wr_en;   // write wins over read

    bank_decode #(.SPARSE_MAP(SPARSE_MAP)) u_dec (
        .en (mem_en),
        .sel(addr[ADDR_W-1:BANK_AW]),
        .cs (cs)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign rd_vec[b] = cs[b] && req.rd;
        if (b == 0) begin : g_rom
            assign wr_vec[b] = 1'b0;
            rom_bank #(.AW(BANK_AW)) u_rom (
                .clk(clk),
                .rst(rst),
                .rd (rd_vec[b]),
                .off(off),
                .q  (bank_q[b])
            );
        end else if (bank_present(b, SPARSE_MAP)) begin : g_ram
            assign wr_vec[b] = cs[b] && req.wr;
            ram_bank #(.AW(BANK_AW)) u_ram (
                .clk(clk),
                .wr (wr_vec[b]),
                .rd (rd_vec[b]),
                .off(off),
                .d  (wdata),
                .q  (bank_q[b])
            );
        end else begin : g_empty
            assign wr_vec[b] = 1'b0;
            assign bank_q[b] = '0;
        end
    end

    // Registered record of which bank answered the previous request.
    always_ff @(posedge clk) begin
        if (rst)
            src_q <= '0;
        else
            src_q <= rd_vec;
    end

    // AND-OR return path: only the recorded bank can reach rdata.
    always_comb begin
        rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++)
            rdata = rdata | (bank_q[b] & {DATA_W{src_q[b]}});
    end

    assign rvalid  = |src_q;
    assign bank_cs = cs;
endmodule

// File: rtl/mem_subsys_chk.sv
module mem_subsys_chk #(
    parameter int ADDR_W     = 12,
    parameter bit SPARSE_MAP = 1'b0
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_en,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        rdata,
    input logic              rvalid,
    input logic [3:0]        bank_cs
);
    p_onehot_cs_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bank_cs));

    p_decode_r2: assert property (@(posedge clk) disable iff (rst)
        (mem_en && (!SPARSE_MAP || !addr[ADDR_W-2])) |-> bank_cs[addr[ADDR_W-1:ADDR_W-2]]);

    p_no_enable_r3: assert property (@(posedge clk) disable iff (rst)
        !mem_en |-> (bank_cs == 4'b0000));

    p_write_wins_r7: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !rvalid);

    p_valid_cause_r8: assert property (@(posedge clk) disable iff (rst)
        rvalid |-> $past(mem_en && rd_en && !wr_en && (bank_cs != 4'b0000)));

    p_zero_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !rvalid |-> (rdata == 8'h00));

    p_sparse_holes_r9: assert property (@(posedge clk) disable iff (rst)
        SPARSE_MAP |-> (!bank_cs[1] && !bank_cs[3]));
endmodule

bind mem_subsys mem_subsys_chk #(.ADDR_W(ADDR_W), .SPARSE_MAP(SPARSE_MAP)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .mem_en (mem_en),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .addr   (addr),
    .rdata  (rdata),
    .rvalid (rvalid),
    .bank_cs(bank_cs)
);

// File: tb/tb_mem_subsys.sv
module tb_mem_subsys;
    localparam int AW = 12;
    localparam int BW = AW - 2;

    typedef struct {
        logic       v;
        logic [7:0] d;
        logic       vs;
        logic [7:0] ds;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mem_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata, rdata_s;
    logic rvalid, rvalid_s;
    logic [3:0] cs, cs_s;

    int checks = 0;
    int fails  = 0;
    exp_t q[$];
    logic [7:0] mdl   [int];
    logic [7:0] mdl_s [int];

    always #10 clk = ~clk;

    mem_subsys #(.ADDR_W(AW), .SPARSE_MAP(1'b0)) dut (
        .clk(clk), .rst(rst), .mem_en(mem_en), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .bank_cs(cs));

    mem_subsys #(.ADDR_W(AW), .SPARSE_MAP(1'b1)) dut_sparse (
        .clk(clk), .rst(rst), .mem_en(mem_en), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata_s), .rvalid(rvalid_s), .bank_cs(cs_s));

    function automatic logic [7:0] rom_exp(input logic [AW-1:0] a);
        logic [31:0] o;
        o = 32'(a[BW-1:0]);
        return o[7:0] ^ {o[11:8], o[11:8]} ^ 8'h5A;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic op(input logic en, input logic we, input logic oe,
                      input logic [AW-1:0] a, input logic [7:0] d, input string tag);
        int sel;
        logic go;
        exp_t e;
        @(negedge clk);
        mem_en = en; wr_en = we; rd_en = oe; addr = a; wdata = d;
        #1;
        sel = int'(a[AW-1:BW]);
        check({tag, " cs dense"}, 32'(cs), en ? 32'(1 << sel) : 32'(0));
        check({tag, " cs sparse"}, 32'(cs_s), (en && sel % 2 == 0) ? 32'(1 << sel) : 32'(0));
        go = en && oe && !we;
        e.tag = tag;
        e.v  = go;
        e.d  = !go ? 8'h00 : (sel == 0 ? rom_exp(a) : mdl[int'(a)]);
        e.vs = go && (sel % 2 == 0);
        e.ds = !e.vs ? 8'h00 : (sel == 0 ? rom_exp(a) : mdl_s[int'(a)]);
        q.push_back(e);
        if (en && we && sel != 0) mdl[int'(a)] = d;
        if (en && we && sel == 2) mdl_s[int'(a)] = d;
    endtask

    always @(posedge clk) begin
        exp_t e;
        #2;
        if (q.size() > 0) begin
            e = q.pop_front();
            check({e.tag, " rvalid dense"}, 32'(rvalid), 32'(e.v));
            check({e.tag, " rdata dense"}, 32'(rdata), 32'(e.d));
            check({e.tag, " rvalid sparse"}, 32'(rvalid_s), 32'(e.vs));
            check({e.tag, " rdata sparse"}, 32'(rdata_s), 32'(e.ds));
        end
    end

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        repeat (3) @(negedge clk);
        #1;
        check("R1 rvalid in reset", 32'(rvalid), 32'(0));
        check("R1 rdata in reset", 32'(rdata), 32'(0));
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 rvalid after reset", 32'(rvalid), 32'(0));
        check("R1 rdata after reset", 32'(rdata_s), 32'(0));

        op(0, 0, 1, 12'h123, 8'h00, "R3 idle read");
        // bank boundaries, first and last address of each bank
        for (int b = 1; b < 4; b++) begin
            op(1, 1, 0, 12'(b * 1024), 8'(8'h10 + b), "R5 write first");
            op(1, 1, 0, 12'(b * 1024 + 1023), 8'(8'h20 + b), "R5 write last");
            op(1, 1, 0, 12'(b * 1024 + 12'h055), 8'(8'h30 + b), "R5 write mid");
        end
        for (int b = 0; b < 4; b++) begin
            op(1, 0, 1, 12'(b * 1024), 8'h00, "R2 R4 read first");
            op(1, 0, 1, 12'(b * 1024 + 1023), 8'h00, "R2 R4 read last");
        end
        // ROM write ignored
        op(1, 1, 0, 12'h055, 8'hFF, "R6 rom write");
        op(1, 0, 1, 12'h055, 8'h00, "R6 rom readback");
        for (int b = 1; b < 4; b++)
            op(1, 0, 1, 12'(b * 1024 + 12'h055), 8'h00, "R6 other banks");
        // disabled write
        op(0, 1, 0, 12'h455, 8'h00, "R3 disabled write");
        op(1, 0, 1, 12'h455, 8'h00, "R3 readback");
        // write priority
        op(1, 1, 1, 12'h866, 8'h77, "R7 write and read");
        op(1, 0, 1, 12'h866, 8'h00, "R7 readback");
        // output enable low
        op(1, 0, 0, 12'h866, 8'h00, "R8 oe low");
        op(0, 0, 1, 12'h866, 8'h00, "R8 enable low");
        // sparse holes
        op(1, 1, 0, 12'hC55, 8'h99, "R9 write hole");
        op(1, 1, 0, 12'h455, 8'h88, "R9 write hole low");
        op(1, 0, 1, 12'h855, 8'h00, "R9 bank2 unchanged");
        op(1, 0, 1, 12'hC55, 8'h00, "R9 read hole");
        op(1, 0, 1, 12'h455, 8'h00, "R9 read hole low");
        op(1, 0, 1, 12'h055, 8'h00, "R9 bank0 unchanged");
        // pseudo-random write/read pairs
        lf = 16'hACE1;
        for (int i = 0; i < 60; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            op(1, 1, 0, lf[AW-1:0], lf[15:8], "R5 random write");
            op(1, 0, 1, lf[AW-1:0], 8'h00, "R5 R4 random read");
            op(1, lf[0], ~lf[0], lf[AW-1:0] ^ 12'h001, 8'h5C, "R8 random mix");
        end
        op(0, 0, 0, '0, 8'h00, "R8 tail");
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule